// File: doc/BRIEF.md
# Cache Miss Address Buffer

This block keeps track of cache misses that are waiting on the external system. A miss arrives with its 44-bit physical address and access size. The block decides from the top address bit whether the access targets memory or I/O space. Memory requests are widened to the whole 64-byte block that holds the address. I/O addresses pass through unchanged. The block records each miss in a free slot and sends it to the system through a valid/ready request port, in the order the misses were accepted.

Each slot stays busy until the system answers for it. A fill response frees the slot quietly. A nonexistent-address response also frees the slot, and it raises a one-cycle error pulse that carries the slot's address. A second memory miss to a block that is already outstanding joins the existing slot and takes no new one. Full and empty flags, together with the miss-side ready, give the cache controller back-pressure. Misses are presented only after the second-level cache lookup has missed. The system answers only for slots it has already been sent.

Top module: `miss_addr_buf`

## Requirements
- R1: After a synchronous active-low reset, `buf_empty` is 1, `buf_full` is 0, `miss_ready` is 1, and both `req_valid` and `err_valid` are 0.
- R2: A miss whose address bit 43 is 0 is a memory request. It is issued with `req_io` = 0, with address bits [5:0] cleared and bits [43:6] unchanged.
- R3: A miss whose address bit 43 is 1 is an I/O request. It is issued with `req_io` = 1 and the address unchanged.
- R4: Accepted misses that take a new slot are issued in acceptance order, one per handshake (`req_valid` and `req_ready` both high). A request first shows on `req_valid` in the cycle after its acceptance. While `req_ready` is low, `req_id`, `req_addr`, `req_io` and `req_size` hold steady.
- R5: A memory miss whose address bits [43:6] equal those of a busy memory slot is accepted, but it produces no new request and takes no slot. I/O misses never merge.
- R6: The buffer has eight slots. When all eight are busy, `buf_full` is 1 and `miss_ready` is 0. A miss offered in that cycle is not accepted and never produces a request.
- R7: A fill response (`fill_valid`, `fill_id`) frees the named slot and raises no error. `buf_empty` returns to 1 once every slot is free.
- R8: A nonexistent-address response (`nxm_valid`, `nxm_id`) frees the named slot. In the next cycle only, `err_valid` is 1, with `err_id` set to that slot and `err_addr` set to the address the slot issued.
- R9: A new slot is always the lowest-numbered free slot. `req_id` reports that slot number.
- R10: `req_size` carries the 2-bit access size of the miss that took the slot (0 byte, 1 word, 2 longword, 3 quadword).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | A miss is offered |
| miss_addr | input | 44 | Physical address of the miss |
| miss_size | input | 2 | Access size of the miss |
| miss_ready | output | 1 | The buffer can take a miss this cycle |
| req_valid | output | 1 | A request is offered to the system |
| req_ready | input | 1 | The system takes the offered request |
| req_id | output | 3 | Slot number of the offered request |
| req_addr | output | 44 | Request address (block-aligned for memory) |
| req_io | output | 1 | 1 for I/O space, 0 for memory space |
| req_size | output | 2 | Access size of the request |
| fill_valid | input | 1 | Fill response for a slot |
| fill_id | input | 3 | Slot that the fill frees |
| nxm_valid | input | 1 | Nonexistent-address response for a slot |
| nxm_id | input | 3 | Slot that the error response frees |
| err_valid | output | 1 | One-cycle error pulse |
| err_id | output | 3 | Slot that took the error |
| err_addr | output | 44 | Address of the slot that took the error |
| buf_full | output | 1 | All slots are busy |
| buf_empty | output | 1 | No slot is busy |

## Verification
A lost or stuck busy bit is visible at the ports. It can let a later miss to the same block be issued twice, or swallow a miss that should have been issued. It can also make the next slot number differ from the lowest free one, or leave `buf_full`/`buf_empty` wrong in the very cycle after the response. A corrupted order pointer shows one cycle after acceptance, as a `req_id` or address out of sequence. A stale stored address shows either on the request or on the `err_addr` of the cycle after a nonexistent-address response. The bench keeps its own slot model and walks full and empty conditions, stalls, merges, responses arriving out of order and an address sweep across both spaces. It compares every port against that model.

// File: rtl/mab_pkg.sv
// Package: shared constants and access-size codes for the miss address buffer.
// Assumes: defaults describe a 44-bit physical address, 64-byte blocks, eight slots.
package mab_pkg;

    localparam int unsigned PA_BITS     = 44;
    localparam int unsigned BLOCK_BYTES = 64;
    localparam int unsigned SLOT_COUNT  = 8;
    localparam int unsigned SIZE_BITS   = 2;

    // Access size of the internal reference that missed.
    typedef enum logic [SIZE_BITS-1:0] {
        ACC_BYTE = 2'd0,
        ACC_WORD = 2'd1,
        ACC_LONG = 2'd2,
        ACC_QUAD = 2'd3
    } acc_size_e;

endpackage

// File: rtl/mab_slot_pick.sv
// Module: finds the lowest-numbered free slot.
// Assumes: busy[i] = 1 marks slot i as taken; any_free is 0 when all are taken.
module mab_slot_pick #(
    parameter int unsigned N    = 8,
    parameter int unsigned ID_W = $clog2(N)
) (
    input  logic [N-1:0]    busy,
    output logic            any_free,
    output logic [ID_W-1:0] idx
);

    // Priority scan from the top down, so the lowest free slot wins.
    always_comb begin
        idx      = '0;
        any_free = 1'b0;
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                idx      = ID_W'(i);
                any_free = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mab_order_fifo.sv
// Module: circular FIFO of slot numbers that keeps requests in issue order.
// Assumes: DEPTH is a power of two; the caller never pushes when full or pops when empty.
module mab_order_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         not_empty
);

    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = PTR_W + 1;

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q;
    logic [PTR_W-1:0] rd_q;
    logic [CNT_W-1:0] cnt_q;

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= wr_q + 1'b1;
            if (pop)  rd_q <= rd_q + 1'b1;
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Storage write; data needs no reset because cnt_q guards reads.
    always_ff @(posedge clk) begin
        if (push) mem_q[wr_q] <= din;
    end

    assign dout      = mem_q[rd_q];
    assign not_empty = (cnt_q != '0);

    // R4: the order queue never overflows or underflows.
    a_r4_fifo_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |-> cnt_q < CNT_W'(DEPTH));
    a_r4_fifo_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> cnt_q != '0);

endmodule

// File: rtl/mab_entry_store.sv
// Module: per-slot busy/issued state, stored address, space and size, plus the block match.
// Assumes: allocation targets only a free slot; responses name busy, issued slots.
module mab_entry_store #(
    parameter int unsigned N     = 8,
    parameter int unsigned PA_W  = 44,
    parameter int unsigned OFF_W = 6,
    parameter int unsigned SZ_W  = 2,
    parameter int unsigned ID_W  = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_en,
    input  logic [ID_W-1:0] alloc_idx,
    input  logic [PA_W-1:0] alloc_addr,
    input  logic            alloc_io,
    input  logic [SZ_W-1:0] alloc_size,
    input  logic            issue_en,
    input  logic [ID_W-1:0] issue_idx,
    input  logic [N-1:0]    retire_vec,
    input  logic [PA_W-1:0] probe_addr,
    input  logic            probe_en,
    input  logic [ID_W-1:0] err_idx,
    output logic [N-1:0]    valid_vec,
    output logic [N-1:0]    issued_vec,
    output logic [N-1:0]    match_vec,
    output logic [PA_W-1:0] rd_addr,
    output logic            rd_io,
    output logic [SZ_W-1:0] rd_size,
    output logic [PA_W-1:0] err_addr
);

    logic [PA_W-1:0] addr_q [N];
    logic [SZ_W-1:0] size_q [N];
    logic [N-1:0]    io_q;

    for (genvar g = 0; g < N; g++) begin : g_slot
        // Busy and issued flags of one slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_vec[g]  <= 1'b0;
                issued_vec[g] <= 1'b0;
            end else if (alloc_en && alloc_idx == ID_W'(g)) begin
                valid_vec[g]  <= 1'b1;
                issued_vec[g] <= 1'b0;
            end else if (retire_vec[g]) begin
                valid_vec[g]  <= 1'b0;
                issued_vec[g] <= 1'b0;
            end else if (issue_en && issue_idx == ID_W'(g)) begin
                issued_vec[g] <= 1'b1;
            end
        end

        // Payload capture on allocation; the busy flag guards use, so no reset.
        always_ff @(posedge clk) begin
            if (alloc_en && alloc_idx == ID_W'(g)) begin
                addr_q[g] <= alloc_addr;
                io_q[g]   <= alloc_io;
                size_q[g] <= alloc_size;
            end
        end

        // Block compare against a memory miss; a slot that is leaving is not a target.
        assign match_vec[g] = probe_en && valid_vec[g] && !retire_vec[g] && !io_q[g]
                              && (addr_q[g][PA_W-1:OFF_W] == probe_addr[PA_W-1:OFF_W]);

        // R7: a response frees its slot at the next edge.
        a_r7_retire_clears: assert property (@(posedge clk) disable iff (!rst_n)
            retire_vec[g] |=> !valid_vec[g]);
    end

    assign rd_addr  = addr_q[issue_idx];
    assign rd_io    = io_q[issue_idx];
    assign rd_size  = size_q[issue_idx];
    assign err_addr = addr_q[err_idx];

    // R9: allocation only ever lands on a free slot.
    a_r9_alloc_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !valid_vec[alloc_idx]);

    // R5: no two busy memory slots ever own the same block.
    a_r5_single_block_owner: assert property (@(posedge clk) disable iff (!rst_n)
        probe_en |-> $countones(match_vec) <= 1);

endmodule

// File: rtl/miss_addr_buf.sv
// Module: top of the cache miss address buffer. Accepts misses, merges memory
// misses to the same block, issues requests in order, retires on fill or
// nonexistent-address response, and flags the error one cycle later.
// Assumes: responses name only issued, busy slots; one miss offered per cycle.
module miss_addr_buf
    import mab_pkg::*;
#(
    parameter int unsigned PA_W      = PA_BITS,
    parameter int unsigned BLK_BYTES = BLOCK_BYTES,
    parameter int unsigned N_SLOTS   = SLOT_COUNT,
    parameter int unsigned SZ_W      = SIZE_BITS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       miss_valid,
    input  logic [PA_W-1:0]            miss_addr,
    input  logic [SZ_W-1:0]            miss_size,
    output logic                       miss_ready,
    output logic                       req_valid,
    input  logic                       req_ready,
    output logic [$clog2(N_SLOTS)-1:0] req_id,
    output logic [PA_W-1:0]            req_addr,
    output logic                       req_io,
    output logic [SZ_W-1:0]            req_size,
    input  logic                       fill_valid,
    input  logic [$clog2(N_SLOTS)-1:0] fill_id,
    input  logic                       nxm_valid,
    input  logic [$clog2(N_SLOTS)-1:0] nxm_id,
    output logic                       err_valid,
    output logic [$clog2(N_SLOTS)-1:0] err_id,
    output logic [PA_W-1:0]            err_addr,
    output logic                       buf_full,
    output logic                       buf_empty
);

    localparam int unsigned ID_W  = $clog2(N_SLOTS);
    localparam int unsigned OFF_W = $clog2(BLK_BYTES);

    logic              miss_is_io;
    logic [PA_W-1:0]   miss_aligned;
    logic [N_SLOTS-1:0] valid_vec;
    logic [N_SLOTS-1:0] issued_vec;
    logic [N_SLOTS-1:0] match_vec;
    logic [N_SLOTS-1:0] retire_vec;
    logic              any_free;
    logic [ID_W-1:0]   free_idx;
    logic              accept;
    logic              merge_hit;
    logic              alloc_en;
    logic              issue_en;
    logic              queue_has;
    logic [PA_W-1:0]   err_lookup;

    // Space decode and block alignment of the incoming miss.
    assign miss_is_io   = miss_addr[PA_W-1];
    assign miss_aligned = miss_is_io ? miss_addr
                                     : {miss_addr[PA_W-1:OFF_W], {OFF_W{1'b0}}};

    // Response decode into one retire bit per slot.
    always_comb begin
        for (int i = 0; i < int'(N_SLOTS); i++) begin
            retire_vec[i] = (fill_valid && fill_id == ID_W'(i))
                         || (nxm_valid  && nxm_id  == ID_W'(i));
        end
    end

    // Back-pressure and allocation control.
    assign buf_full   = &valid_vec;
    assign buf_empty  = ~|valid_vec;
    assign miss_ready = !buf_full;
    assign accept     = miss_valid && miss_ready;
    assign merge_hit  = |match_vec;
    assign alloc_en   = accept && !merge_hit && any_free;
    assign req_valid  = queue_has;
    assign issue_en   = req_valid && req_ready;

    mab_slot_pick #(
        .N    (N_SLOTS),
        .ID_W (ID_W)
    ) u_pick (
        .busy     (valid_vec),
        .any_free (any_free),
        .idx      (free_idx)
    );

    mab_order_fifo #(
        .DEPTH (N_SLOTS),
        .W     (ID_W)
    ) u_order (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (alloc_en),
        .din       (free_idx),
        .pop       (issue_en),
        .dout      (req_id),
        .not_empty (queue_has)
    );

    mab_entry_store #(
        .N     (N_SLOTS),
        .PA_W  (PA_W),
        .OFF_W (OFF_W),
        .SZ_W  (SZ_W),
        .ID_W  (ID_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc_en),
        .alloc_idx  (free_idx),
        .alloc_addr (miss_aligned),
        .alloc_io   (miss_is_io),
        .alloc_size (miss_size),
        .issue_en   (issue_en),
        .issue_idx  (req_id),
        .retire_vec (retire_vec),
        .probe_addr (miss_addr),
        .probe_en   (miss_valid && !miss_is_io),
        .err_idx    (nxm_id),
        .valid_vec  (valid_vec),
        .issued_vec (issued_vec),
        .match_vec  (match_vec),
        .rd_addr    (req_addr),
        .rd_io      (req_io),
        .rd_size    (req_size),
        .err_addr   (err_lookup)
    );

    // Registered error pulse carrying the failed slot and its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_id    <= '0;
            err_addr  <= '0;
        end else begin
            err_valid <= nxm_valid;
            if (nxm_valid) begin
                err_id   <= nxm_id;
                err_addr <= err_lookup;
            end
        end
    end

    // R2: memory requests leave block-aligned.
    a_r2_mem_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_io |-> req_addr[OFF_W-1:0] == '0);

    // R4: a stalled request holds its fields.
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_id) && $stable(req_addr)
                                    && $stable(req_io) && $stable(req_size));

    // R7: responses only name slots that are busy and already issued.
    a_r7_response_to_issued: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> valid_vec[fill_id] && issued_vec[fill_id]);
    a_r8_error_to_issued: assert property (@(posedge clk) disable iff (!rst_n)
        nxm_valid |-> valid_vec[nxm_id] && issued_vec[nxm_id]);

endmodule

// File: tb/tb_miss_addr_buf.sv
`timescale 1ns/1ps
module tb_miss_addr_buf;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [43:0] miss_addr = '0;
    logic [1:0]  miss_size = '0;
    logic        miss_ready;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [2:0]  req_id;
    logic [43:0] req_addr;
    logic        req_io;
    logic [1:0]  req_size;
    logic        fill_valid = 1'b0;
    logic [2:0]  fill_id = '0;
    logic        nxm_valid = 1'b0;
    logic [2:0]  nxm_id = '0;
    logic        err_valid;
    logic [2:0]  err_id;
    logic [43:0] err_addr;
    logic        buf_full;
    logic        buf_empty;

    always #10 clk = ~clk;

    miss_addr_buf dut (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_size(miss_size),
        .miss_ready(miss_ready),
        .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
        .req_addr(req_addr), .req_io(req_io), .req_size(req_size),
        .fill_valid(fill_valid), .fill_id(fill_id),
        .nxm_valid(nxm_valid), .nxm_id(nxm_id),
        .err_valid(err_valid), .err_id(err_id), .err_addr(err_addr),
        .buf_full(buf_full), .buf_empty(buf_empty)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // Bench model of the slots and of the expected request stream.
    bit          mv  [8];
    bit          mio [8];
    logic [43:0] ma  [8];
    logic [2:0]  q_id   [$];
    logic [43:0] q_addr [$];
    logic        q_io   [$];
    logic [1:0]  q_sz   [$];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit model_full();
        for (int j = 0; j < 8; j++) if (!mv[j]) return 0;
        return 1;
    endfunction

    function automatic bit model_empty();
        for (int j = 0; j < 8; j++) if (mv[j]) return 0;
        return 1;
    endfunction

    task automatic chk_flags(input string req);
        @(negedge clk);
        check(buf_full == model_full(), {req, " buf_full"}, 64'(buf_full), 64'(model_full()));
        check(buf_empty == model_empty(), {req, " buf_empty"}, 64'(buf_empty), 64'(model_empty()));
    endtask

    // Offer one miss for one cycle and update the model (R5, R6, R9).
    task automatic send(input logic [43:0] a, input logic [1:0] sz);
        bit exp_ready;
        bit merged;
        int slot;
        @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = a;
        miss_size  = sz;
        exp_ready  = !model_full();
        check(miss_ready == exp_ready, "R6 miss_ready", 64'(miss_ready), 64'(exp_ready));
        if (exp_ready) begin
            merged = 0;
            if (!a[43]) begin
                for (int j = 0; j < 8; j++)
                    if (mv[j] && !mio[j] && ma[j][43:6] == a[43:6]) merged = 1;
            end
            if (!merged) begin
                slot = -1;
                for (int j = 7; j >= 0; j--) if (!mv[j]) slot = j;
                mv[slot]  = 1;
                mio[slot] = a[43];
                ma[slot]  = a[43] ? a : {a[43:6], 6'd0};
                q_id.push_back(3'(slot));
                q_addr.push_back(ma[slot]);
                q_io.push_back(a[43]);
                q_sz.push_back(sz);
            end
        end
        @(posedge clk);
        #1 miss_valid = 1'b0;
    endtask

    // Take every expected request and compare each field (R2, R3, R4, R9, R10).
    task automatic drain(input bit stall);
        logic [2:0] id0;
        bit st = stall;
        while (q_id.size() > 0) begin
            @(negedge clk);
            if (st) begin
                req_ready = 1'b0;
                check(req_valid == 1'b1, "R4 stalled valid", 64'(req_valid), 64'd1);
                id0 = req_id;
                @(negedge clk);
                @(negedge clk);
                check(req_valid && req_id == id0, "R4 hold under stall", 64'(req_id), 64'(id0));
                st = 0;
            end
            check(req_valid == 1'b1, "R4 req_valid", 64'(req_valid), 64'd1);
            check(req_id == q_id[0], "R9 req_id order", 64'(req_id), 64'(q_id[0]));
            check(req_addr == q_addr[0], q_io[0] ? "R3 io addr" : "R2 mem addr",
                  64'(req_addr), 64'(q_addr[0]));
            check(req_io == q_io[0], "R3 req_io", 64'(req_io), 64'(q_io[0]));
            check(req_size == q_sz[0], "R10 req_size", 64'(req_size), 64'(q_sz[0]));
            req_ready = 1'b1;
            void'(q_id.pop_front());
            void'(q_addr.pop_front());
            void'(q_io.pop_front());
            void'(q_sz.pop_front());
            @(posedge clk);
            #1 req_ready = 1'b0;
        end
        @(negedge clk);
        check(req_valid == 1'b0, "R5 no extra request", 64'(req_valid), 64'd0);
    endtask

    // Respond for one issued slot with a fill or an error (R7, R8).
    task automatic retire(input int id, input bit nxm);
        @(negedge clk);
        if (nxm) begin nxm_valid = 1'b1; nxm_id = 3'(id); end
        else     begin fill_valid = 1'b1; fill_id = 3'(id); end
        @(negedge clk);
        nxm_valid  = 1'b0;
        fill_valid = 1'b0;
        mv[id] = 0;
        if (nxm) begin
            check(err_valid == 1'b1, "R8 err_valid", 64'(err_valid), 64'd1);
            check(err_id == 3'(id), "R8 err_id", 64'(err_id), 64'(id));
            check(err_addr == ma[id], "R8 err_addr", 64'(err_addr), 64'(ma[id]));
            @(negedge clk);
            check(err_valid == 1'b0, "R8 one-cycle pulse", 64'(err_valid), 64'd0);
        end else begin
            check(err_valid == 1'b0, "R7 fill raises no error", 64'(err_valid), 64'd0);
        end
    endtask

    task automatic retire_all(input bit nxm);
        for (int j = 0; j < 8; j++) if (mv[j]) retire(j, nxm);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [43:0] a;
        for (int j = 0; j < 8; j++) begin mv[j] = 0; mio[j] = 0; ma[j] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(buf_empty == 1'b1, "R1 empty", 64'(buf_empty), 64'd1);
        check(buf_full == 1'b0, "R1 full", 64'(buf_full), 64'd0);
        check(miss_ready == 1'b1, "R1 ready", 64'(miss_ready), 64'd1);
        check(req_valid == 1'b0, "R1 req_valid", 64'(req_valid), 64'd0);
        check(err_valid == 1'b0, "R1 err_valid", 64'(err_valid), 64'd0);

        // R6, R9: fill all eight slots with distinct memory blocks.
        for (int i = 0; i < 8; i++) begin
            a = (44'(i + 1) << 6) | 44'((i * 7) % 64) | (44'(i) << 24);
            send(a, 2'(i % 4));
        end
        chk_flags("R6 full after eight");
        send(44'h0000_0ABC_DE1, 2'd3);   // R6: offered while full, must vanish
        drain(1'b1);
        // R9: free slots 3 and 5, new misses must land there in that order.
        retire(3, 1'b0);
        retire(5, 1'b1);
        chk_flags("R7 after two frees");
        send(44'h0123_4567_89A, 2'd1);
        send(44'h0222_0000_040, 2'd2);
        drain(1'b0);
        retire(6, 1'b1);
        retire_all(1'b0);
        chk_flags("R7 empty after all fills");

        // R5: memory merges; R3: I/O never merges.
        send(44'h0456_7890_0C0, 2'd0);
        send(44'h0456_7890_0D5, 2'd1);   // same block, merges
        drain(1'b0);
        send(44'h0456_7890_0FF, 2'd3);   // same block while issued, merges
        drain(1'b0);
        send(44'h8000_0012_345, 2'd2);
        send(44'h8000_0012_345, 2'd2);   // identical I/O, two requests
        send(44'h8456_7890_0C7, 2'd0);   // I/O with same low block bits as memory slot
        drain(1'b1);
        retire_all(1'b1);
        chk_flags("R7 empty after merges");

        // Sweep across both spaces, with and without merges.
        for (int i = 0; i < 24; i++) begin
            a = 44'(64'(i + 1) * 64'h9E37_79B1_7F4A) & 44'h7FF_FFFF_FFFF;
            if (i % 4 == 3) a[43] = 1'b1;
            send(a, 2'(i));
            if (i % 2 == 0) send(a ^ 44'h0000_0000_02A, 2'(i + 1));
            if (i % 5 == 0) send(a + 44'h0000_0010_000, 2'(i + 2));
            drain(i % 3 == 1);
            retire_all(i % 3 == 0);
            chk_flags("R7 sweep empty");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule